// File: doc/BRIEF.md
# External Zone Chip-Select Decoder

This block sits between a CPU address path and an external memory bus. For every valid access it sorts a 22-bit word address into one of five external zones, lowers the matching active-low chip select and drives a 19-bit external address. Zones 0 and 1 share one select. Zones 6 and 7 share another. Zones 2 and 6 produce the same external addresses and differ only in which select goes low. The top 16K words of zone 7 can be mapped in or out. When it is mapped out, an access to its window selects the on-chip boot ROM instead, and no external select is lowered.

The zone 7 mapping flag takes the value of a boot-mode pin while reset is held. After reset, software changes it by writing a configuration word, and bit 8 of that word is the mapping flag. Results are registered, so each access appears at the outputs one clock edge after it is presented.

A small state machine holds the class of the last access:
- IDLE: no access.
- EXT: an external zone is selected.
- ROM: boot ROM hit.
- MISS: the address is in no mapped zone.

On every edge it goes to the class the decoder reports when the access strobe is high, and to IDLE when the strobe is low. Every state can reach every other state in one edge.

Top module: `xz_chipsel`

## Requirements
- R1: While reset is held and directly after it, all three chip selects are high, `rom_sel` and `dec_miss` are low, and `xaddr` and `zone_idx` are zero.
- R2: CPU addresses 0x2000–0x3FFF (zone 0) and 0x4000–0x5FFF (zone 1) lower `cs01_n`, with `xaddr` equal to the CPU address. For zone 0, xaddr bit 13 is 1 and bit 14 is 0. For zone 1, bit 13 is 0 and bit 14 is 1. `zone_idx` is 0 or 1.
- R3: CPU addresses 0x080000–0x0FFFFF lower `cs2_n`, with `xaddr` = address − 0x080000 (0x00000 to 0x7FFFF) and `zone_idx` = 2.
- R4: CPU addresses 0x100000–0x17FFFF lower `cs67_n`, with `xaddr` = address − 0x100000 and `zone_idx` = 6.
- R5: While mapping is on, CPU addresses 0x3FC000–0x3FFFFF lower `cs67_n`, with `xaddr` = 0x7C000 + (address − 0x3FC000) and `zone_idx` = 7.
- R6: While mapping is off, the zone 7 window raises `rom_sel`. No chip select is lowered, and `xaddr` and `zone_idx` are 0.
- R7: The mapping flag equals the level of `boot_pin` while `rst_n` is low.
- R8: A cycle with `cfg_wr` high loads the mapping flag from `cfg_wdata` bit 8. All other bits of `cfg_wdata` have no effect.
- R9: Any other address lowers no chip select, leaves `rom_sel` low and raises `dec_miss` for one cycle. This includes 0x0000–0x1FFF, 0x6000–0x07FFFF, the reserved zones 3–5 at 0x180000–0x3FBFFF, and everything in between.
- R10: The outputs show the access presented at the previous rising edge. After an edge with `acc_valid` low, all outputs are idle as in R1.
- R11: At most one chip select is low in any cycle.
- R12: CPU addresses 0x17C000–0x17FFFF reach the same external addresses as zone 7 (0x7C000–0x7FFFF) on `cs67_n`, whatever the mapping flag is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 22 | CPU word address |
| acc_valid | input | 1 | Access strobe |
| boot_pin | input | 1 | Boot-mode level captured during reset |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word; bit 8 is the mapping flag |
| cs01_n | output | 1 | Shared select, zones 0 and 1 (active low) |
| cs2_n | output | 1 | Select, zone 2 (active low) |
| cs67_n | output | 1 | Shared select, zones 6 and 7 (active low) |
| xaddr | output | 19 | External address |
| zone_idx | output | 3 | Selected zone number, 0 when no select is low |
| rom_sel | output | 1 | Boot ROM hit |
| dec_miss | output | 1 | Address matched no mapped zone |

## Verification
The bench builds the block with its default parameters: a 22-bit CPU address, a 19-bit external address, a 16-bit configuration word and the mapping flag at bit 8. With these values the real zone edges can be tested directly: the first and last word of each zone, the words just outside zones 0 and 1, the reserved gap, and the word just below the zone 7 window. The same values let the bench compare the zone 6 mirror with zone 7 at identical offsets. It does this once after a reset with the pin high, and again after software writes change the flag in both directions.

// File: rtl/xz_pkg.sv
package xz_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXT  = 2'd1,
        ST_ROM  = 2'd2,
        ST_MISS = 2'd3
    } xz_state_e;

    localparam logic [2:0] ZN0 = 3'd0;
    localparam logic [2:0] ZN1 = 3'd1;
    localparam logic [2:0] ZN2 = 3'd2;
    localparam logic [2:0] ZN6 = 3'd6;
    localparam logic [2:0] ZN7 = 3'd7;

    // Block sizes as log2 of word count
    localparam int SMALL_LG = 13;   // zones 0 and 1
    localparam int LARGE_LG = 19;   // zones 2 and 6
    localparam int TOP_LG   = 14;   // zone 7 window
endpackage

// File: rtl/xz_mapctl.sv
module xz_mapctl #(
    parameter int CFG_W   = 16,
    parameter int MAP_BIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_pin,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             map_en
);
    // Reset loads the pin level; a configuration write overrides it later.
    always_ff @(posedge clk) begin
        if (!rst_n)
            map_en <= boot_pin;
        else if (cfg_wr)
            map_en <= cfg_wdata[MAP_BIT];
    end
endmodule

// File: rtl/xz_addr_decode.sv
module xz_addr_decode
    import xz_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int XA_W   = 19
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              map_en,
    output xz_state_e         cls,
    output logic [2:0]        zone,
    output logic [XA_W-1:0]   xa
);
    localparam int SMALL_HI = ADDR_W - SMALL_LG;
    localparam int LARGE_HI = ADDR_W - LARGE_LG;
    localparam int TOP_HI   = ADDR_W - TOP_LG;

    logic [SMALL_HI-1:0] blk_small;
    logic [LARGE_HI-1:0] blk_large;
    logic [TOP_HI-1:0]   blk_top;
    logic in_z0, in_z1, in_z2, in_z6, in_z7;

    assign blk_small = addr[ADDR_W-1:SMALL_LG];
    assign blk_large = addr[ADDR_W-1:LARGE_LG];
    assign blk_top   = addr[ADDR_W-1:TOP_LG];

    assign in_z0 = (blk_small == SMALL_HI'(1));
    assign in_z1 = (blk_small == SMALL_HI'(2));
    assign in_z2 = (blk_large == LARGE_HI'(1));
    assign in_z6 = (blk_large == LARGE_HI'(2));
    assign in_z7 = (&blk_top);

    always_comb begin
        cls  = ST_MISS;
        zone = ZN0;
        xa   = '0;
        if (in_z0) begin
            cls = ST_EXT; zone = ZN0; xa = addr[XA_W-1:0];
        end else if (in_z1) begin
            cls = ST_EXT; zone = ZN1; xa = addr[XA_W-1:0];
        end else if (in_z2) begin
            cls = ST_EXT; zone = ZN2; xa = addr[XA_W-1:0];
        end else if (in_z6) begin
            cls = ST_EXT; zone = ZN6; xa = addr[XA_W-1:0];
        end else if (in_z7) begin
            if (map_en) begin
                cls = ST_EXT; zone = ZN7; xa = addr[XA_W-1:0];
            end else begin
                cls = ST_ROM;
            end
        end
    end
endmodule

// File: rtl/xz_chipsel.sv
module xz_chipsel
    import xz_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int XA_W    = 19,
    parameter int CFG_W   = 16,
    parameter int MAP_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              acc_valid,
    input  logic              boot_pin,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              cs01_n,
    output logic              cs2_n,
    output logic              cs67_n,
    output logic [XA_W-1:0]   xaddr,
    output logic [2:0]        zone_idx,
    output logic              rom_sel,
    output logic              dec_miss
);
    logic            map_en;
    xz_state_e       dec_cls;
    logic [2:0]      dec_zone;
    logic [XA_W-1:0] dec_xa;

    xz_state_e       state_q;
    logic [2:0]      zone_q;
    logic [XA_W-1:0] xa_q;

    xz_mapctl #(.CFG_W(CFG_W), .MAP_BIT(MAP_BIT)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_pin (boot_pin),
        .cfg_wr   (cfg_wr),
        .cfg_wdata(cfg_wdata),
        .map_en   (map_en)
    );

    xz_addr_decode #(.ADDR_W(ADDR_W), .XA_W(XA_W)) u_dec (
        .addr  (cpu_addr),
        .map_en(map_en),
        .cls   (dec_cls),
        .zone  (dec_zone),
        .xa    (dec_xa)
    );

    // State register: next class comes from the decoder while strobed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            zone_q  <= ZN0;
            xa_q    <= '0;
        end else if (acc_valid) begin
            state_q <= dec_cls;
            zone_q  <= dec_zone;
            xa_q    <= dec_xa;
        end else begin
            state_q <= ST_IDLE;
            zone_q  <= ZN0;
            xa_q    <= '0;
        end
    end

    // Output process
    always_comb begin
        cs01_n   = 1'b1;
        cs2_n    = 1'b1;
        cs67_n   = 1'b1;
        rom_sel  = 1'b0;
        dec_miss = 1'b0;
        zone_idx = ZN0;
        xaddr    = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_EXT: begin
                zone_idx = zone_q;
                xaddr    = xa_q;
                if (zone_q == ZN0 || zone_q == ZN1)
                    cs01_n = 1'b0;
                else if (zone_q == ZN2)
                    cs2_n = 1'b0;
                else
                    cs67_n = 1'b0;
            end
            ST_ROM:  rom_sel  = 1'b1;
            ST_MISS: dec_miss = 1'b1;
        endcase
    end
endmodule

// File: rtl/xz_chipsel_chk.sv
module xz_chipsel_chk #(
    parameter int XA_W = 19
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic            cs01_n,
    input logic            cs2_n,
    input logic            cs67_n,
    input logic [XA_W-1:0] xaddr,
    input logic [2:0]      zone_idx,
    input logic            rom_sel,
    input logic            dec_miss
);
    assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~cs01_n, ~cs2_n, ~cs67_n}) <= 1);

    assert_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs01_n || !cs2_n || !cs67_n || rom_sel || dec_miss) |-> $past(acc_valid));

    assert_rom_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (cs01_n && cs2_n && cs67_n && !dec_miss));

    assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_miss |-> (cs01_n && cs2_n && cs67_n && !rom_sel));

    assert_z01_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs01_n |-> (xaddr[13] != xaddr[14]));

    assert_z2_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cs2_n |-> (zone_idx == 3'd2));

    assert_z7_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs67_n && zone_idx == 3'd7) |-> (xaddr[XA_W-1:14] == '1));
endmodule

bind xz_chipsel xz_chipsel_chk #(.XA_W(XA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .cs01_n   (cs01_n),
    .cs2_n    (cs2_n),
    .cs67_n   (cs67_n),
    .xaddr    (xaddr),
    .zone_idx (zone_idx),
    .rom_sel  (rom_sel),
    .dec_miss (dec_miss)
);

// File: tb/tb_xz_chipsel.sv
module tb_xz_chipsel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] cpu_addr = '0;
    logic        acc_valid = 1'b0;
    logic        boot_pin = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        cs01_n, cs2_n, cs67_n, rom_sel, dec_miss;
    logic [18:0] xaddr;
    logic [2:0]  zone_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [2:0]  cs;     // {cs01_n, cs2_n, cs67_n}
        logic        rom;
        logic        miss;
        logic [2:0]  zone;
        logic [18:0] xa;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    xz_chipsel dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .acc_valid(acc_valid),
        .boot_pin(boot_pin), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cs01_n(cs01_n), .cs2_n(cs2_n), .cs67_n(cs67_n), .xaddr(xaddr),
        .zone_idx(zone_idx), .rom_sel(rom_sel), .dec_miss(dec_miss)
    );

    task automatic compare(input exp_t e);
        n_tests++;
        if ({cs01_n, cs2_n, cs67_n} !== e.cs || rom_sel !== e.rom || dec_miss !== e.miss
            || zone_idx !== e.zone || xaddr !== e.xa) begin
            n_fail++;
            $display("FAIL %s: got cs=%b rom=%b miss=%b zone=%0d xa=%h, expected cs=%b rom=%b miss=%b zone=%0d xa=%h",
                     e.req, {cs01_n, cs2_n, cs67_n}, rom_sel, dec_miss, zone_idx, xaddr,
                     e.cs, e.rom, e.miss, e.zone, e.xa);
        end
    endtask

    // Monitor: one result per edge, sampled 1 ns after it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    task automatic push(input logic [2:0] cs, input logic rom, input logic miss,
                        input logic [2:0] zone, input logic [18:0] xa, input string req);
        exp_t e;
        e.cs = cs; e.rom = rom; e.miss = miss; e.zone = zone; e.xa = xa; e.req = req;
        sb.push_back(e);
    endtask

    task automatic access(input logic [21:0] a, input logic [2:0] cs, input logic rom,
                          input logic miss, input logic [2:0] zone, input logic [18:0] xa,
                          input string req);
        @(negedge clk);
        cpu_addr = a; acc_valid = 1'b1; cfg_wr = 1'b0;
        push(cs, rom, miss, zone, xa, req);
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        acc_valid = 1'b0; cfg_wr = 1'b0; cpu_addr = 22'h3FFFFF;
        push(3'b111, 1'b0, 1'b0, 3'd0, 19'd0, req);
    endtask

    task automatic cfg_write(input logic [15:0] d);
        @(negedge clk);
        acc_valid = 1'b0; cfg_wr = 1'b1; cfg_wdata = d;
        push(3'b111, 1'b0, 1'b0, 3'd0, 19'd0, "R10 idle during cfg write");
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst_n = 1'b0; acc_valid = 1'b0; cfg_wr = 1'b0; boot_pin = pin;
        repeat (4) @(negedge clk);
        begin
            exp_t e;
            e.cs = 3'b111; e.rom = 0; e.miss = 0; e.zone = 0; e.xa = 0; e.req = "R1 during reset";
            compare(e);
        end
        rst_n = 1'b1;
        boot_pin = ~pin;   // later pin changes must not matter
        @(posedge clk); #1;
        begin
            exp_t e;
            e.cs = 3'b111; e.rom = 0; e.miss = 0; e.zone = 0; e.xa = 0; e.req = "R1 after reset";
            compare(e);
        end
    endtask

    // Watchdog
    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // Boot with pin high: zone 7 mapped (R7)
        do_reset(1'b1);
        access(22'h002000, 3'b011, 0, 0, 3'd0, 19'h02000, "R2 zone0 first");
        access(22'h003FFF, 3'b011, 0, 0, 3'd0, 19'h03FFF, "R2 zone0 last");
        access(22'h004000, 3'b011, 0, 0, 3'd1, 19'h04000, "R2 zone1 first");
        access(22'h005FFF, 3'b011, 0, 0, 3'd1, 19'h05FFF, "R2 zone1 last");
        access(22'h080000, 3'b101, 0, 0, 3'd2, 19'h00000, "R3 zone2 first");
        access(22'h0FFFFF, 3'b101, 0, 0, 3'd2, 19'h7FFFF, "R3 zone2 last");
        access(22'h100000, 3'b110, 0, 0, 3'd6, 19'h00000, "R4 zone6 first");
        access(22'h17FFFF, 3'b110, 0, 0, 3'd6, 19'h7FFFF, "R4 zone6 last");
        access(22'h3FC000, 3'b110, 0, 0, 3'd7, 19'h7C000, "R5 R7 zone7 first, mapped by pin");
        access(22'h3FFFFF, 3'b110, 0, 0, 3'd7, 19'h7FFFF, "R5 zone7 last");
        access(22'h3FC123, 3'b110, 0, 0, 3'd7, 19'h7C123, "R5 zone7 offset");
        access(22'h17C123, 3'b110, 0, 0, 3'd6, 19'h7C123, "R12 mirror while mapped");
        access(22'h000000, 3'b111, 0, 1, 3'd0, 19'h0, "R9 address zero");
        access(22'h001FFF, 3'b111, 0, 1, 3'd0, 19'h0, "R9 below zone0");
        access(22'h006000, 3'b111, 0, 1, 3'd0, 19'h0, "R9 above zone1");
        access(22'h07FFFF, 3'b111, 0, 1, 3'd0, 19'h0, "R9 below zone2");
        access(22'h180000, 3'b111, 0, 1, 3'd0, 19'h0, "R9 reserved zone start");
        access(22'h2A5A5A, 3'b111, 0, 1, 3'd0, 19'h0, "R9 reserved zone middle");
        access(22'h3FBFFF, 3'b111, 0, 1, 3'd0, 19'h0, "R9 below zone7");
        idle("R10 strobe low clears outputs");
        access(22'h0C0000, 3'b101, 0, 0, 3'd2, 19'h40000, "R11 back to back zone2");
        access(22'h140000, 3'b110, 0, 0, 3'd6, 19'h40000, "R11 back to back zone6 same xa");
        // Software unmaps zone 7, other bits set (R8)
        cfg_write(16'hFEFF);
        access(22'h3FC000, 3'b111, 1, 0, 3'd0, 19'h0, "R8 R6 unmapped zone7 hits rom");
        access(22'h3FFFFF, 3'b111, 1, 0, 3'd0, 19'h0, "R6 unmapped zone7 last");
        access(22'h17C123, 3'b110, 0, 0, 3'd6, 19'h7C123, "R12 mirror while unmapped");
        cfg_write(16'h0100);
        access(22'h3FC123, 3'b110, 0, 0, 3'd7, 19'h7C123, "R8 remapped by bit 8");
        idle("R10 idle");
        // Boot with pin low: zone 7 unmapped (R7)
        do_reset(1'b0);
        access(22'h3FC000, 3'b111, 1, 0, 3'd0, 19'h0, "R7 pin low gives rom");
        access(22'h002ABC, 3'b011, 0, 0, 3'd0, 19'h02ABC, "R2 zone0 after second reset");
        cfg_write(16'h0100);
        access(22'h3FD555, 3'b110, 0, 0, 3'd7, 19'h7D555, "R8 software maps zone7");
        idle("R10 final idle");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule